// File: doc/BRIEF.md
# ST-BUS Clock and Frame Pulse Generator

This block turns a single 32.768 MHz master clock into the timing set used by a serial ST-BUS backplane. One free-running frame counter of 4096 master cycles (one 125 us frame at 8 kHz) drives every output. The four divided clocks at 16.384, 8.192, 4.096 and 2.048 MHz are taken from the low counter bits. Six frame pulses are decoded from the counter value. Each pulse has its own width and polarity, to suit a different bus rate.

Every pulse is centred on the frame boundary, so all of them mark the same instant. A small sequencer with two states gates the counter. In ST_HOLD the counter is held at zero and every output sits at its idle level. In ST_RUN the counter advances by one on each master clock. The transition ST_HOLD to ST_RUN fires when `en` is high. The transition ST_RUN to ST_HOLD fires when `en` is low. A synchronous `rst` forces ST_HOLD from either state. Every output is a register. Each output is computed from the next-state value of the counter, so the ports line up cycle for cycle with the counter.

The frame-start cycle is the first cycle after the edge that moves the sequencer from ST_HOLD to ST_RUN, and then every 4096th cycle after that. Below, "cycle 0" is a frame-start cycle and "cycle -1" is the cycle just before it.

Top module: `stbus_timing_gen`

## Requirements
- R1: While `rst` is sampled high, at the next edge the outputs go idle and stay idle. Idle means all four clocks low, `fp_n_w1`, `fp_n_w2` and `fp_n_w8` high, and `fp_w4`, `sync_rx` and `sync_tx` low.
- R2: While `en` is low the outputs stay idle. The first cycle after `en` is sampled high in ST_HOLD is a frame-start cycle, including after `en` drops in the middle of a frame.
- R3: In ST_RUN, `clk_16m`, `clk_8m`, `clk_4m` and `clk_2m` equal bits 0, 1, 2 and 3 of the frame count, which divides the master clock by 2, 4, 8 and 16. All four clocks are low in cycle 0 and high in cycle -1, so each one falls at the frame boundary.
- R4: Frame-start cycles repeat every 4096 master cycles.
- R5: `fp_n_w1` is active low for one cycle, cycle 0.
- R6: `fp_n_w2` is active low for two cycles, cycle -1 and cycle 0.
- R7: `fp_w4` is active high for four cycles, cycles -2 through 1.
- R8: `fp_n_w8` is active low for eight cycles, cycles -4 through 3.
- R9: `sync_rx` and `sync_tx` are identical. Both are active high for sixteen cycles, cycles -8 through 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the frame counter at zero |
| clk_16m | output | 1 | Master clock divided by 2 |
| clk_8m | output | 1 | Master clock divided by 4 |
| clk_4m | output | 1 | Master clock divided by 8 |
| clk_2m | output | 1 | Master clock divided by 16 |
| fp_n_w1 | output | 1 | Frame pulse, active low, 1 cycle |
| fp_n_w2 | output | 1 | Frame pulse, active low, 2 cycles |
| fp_w4 | output | 1 | Frame pulse, active high, 4 cycles |
| fp_n_w8 | output | 1 | Frame pulse, active low, 8 cycles |
| sync_rx | output | 1 | Receive sync, active high, 16 cycles |
| sync_tx | output | 1 | Transmit sync, active high, 16 cycles |

## Verification
The bench builds the block with its default parameters: a 12-bit frame count and pulse widths of 1, 2, 4, 8 and 16 cycles. At these values a full frame is short enough to walk cycle by cycle. The bench steps through three complete frames, so it sees the wrap from 4095 to 0 several times and checks every pulse edge on both sides of the boundary. Because the widths are the real ones, the counts of active cycles measured in each frame can be compared directly with the required widths.

// File: rtl/stbus_pkg.sv
package stbus_pkg;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    // pulse slots: 0 narrow, 1 double, 2 quad, 3 octal, 4 receive sync, 5 transmit sync
    localparam int NUM_PULSES = 6;
    localparam bit [NUM_PULSES-1:0] PULSE_ACTIVE_HIGH = 6'b110100;

endpackage

// File: rtl/stbus_frame_seq.sv
module stbus_frame_seq
    import stbus_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic             run_q,
    output logic             run_nxt,
    output logic [CNT_W-1:0] cnt_nxt
);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_nxt;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_nxt = '0;
        unique case (state_q)
            ST_HOLD: begin
                if (en) state_d = ST_RUN;
                cnt_nxt = '0;
            end
            ST_RUN: begin
                if (en) begin
                    cnt_nxt = cnt_q + 1'b1;
                end else begin
                    state_d = ST_HOLD;
                    cnt_nxt = '0;
                end
            end
        endcase
    end

    assign run_q   = (state_q == ST_RUN);
    assign run_nxt = (state_d == ST_RUN);

endmodule

// File: rtl/stbus_clk_divider.sv
module stbus_clk_divider #(
    parameter int CNT_W      = 12,
    parameter int DIV_STAGES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run_nxt,
    input  logic [CNT_W-1:0]      cnt_nxt,
    output logic [DIV_STAGES-1:0] clk_o
);

    generate
        for (genvar s = 0; s < DIV_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) clk_o[s] <= 1'b0;
                else     clk_o[s] <= run_nxt & cnt_nxt[s];
            end
        end
    endgenerate

endmodule

// File: rtl/stbus_pulse_shaper.sv
module stbus_pulse_shaper #(
    parameter int CNT_W       = 12,
    parameter int WIDTH       = 1,
    parameter bit ACTIVE_HIGH = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_nxt,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic             pulse_o
);

    localparam int unsigned FRAME_LEN = 1 << CNT_W;
    localparam int unsigned HEAD      = (WIDTH + 1) / 2;
    localparam int unsigned TAIL      = WIDTH / 2;
    localparam logic [CNT_W-1:0] HEAD_LIM   = CNT_W'(HEAD);
    localparam logic [CNT_W-1:0] TAIL_START = CNT_W'(FRAME_LEN - TAIL);

    logic active;

    generate
        if (TAIL == 0) begin : g_head_only
            assign active = (cnt_nxt < HEAD_LIM);
        end else begin : g_straddle
            assign active = (cnt_nxt < HEAD_LIM) || (cnt_nxt >= TAIL_START);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                     pulse_o <= ~ACTIVE_HIGH;
        else if (run_nxt && active)  pulse_o <= ACTIVE_HIGH;
        else                         pulse_o <= ~ACTIVE_HIGH;
    end

endmodule

// File: rtl/stbus_timing_gen.sv
module stbus_timing_gen
    import stbus_pkg::*;
#(
    parameter int FRAME_LOG2 = 12,
    parameter int PW_NARROW  = 1,
    parameter int PW_DOUBLE  = 2,
    parameter int PW_QUAD    = 4,
    parameter int PW_OCT     = 8,
    parameter int PW_SYNC    = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic clk_16m,
    output logic clk_8m,
    output logic clk_4m,
    output logic clk_2m,
    output logic fp_n_w1,
    output logic fp_n_w2,
    output logic fp_w4,
    output logic fp_n_w8,
    output logic sync_rx,
    output logic sync_tx
);

    localparam int DIV_STAGES = 4;
    localparam int PW [NUM_PULSES] = '{PW_NARROW, PW_DOUBLE, PW_QUAD, PW_OCT, PW_SYNC, PW_SYNC};

    logic                  run_q;
    logic                  run_nxt;
    logic [FRAME_LOG2-1:0] cnt_nxt;
    logic [DIV_STAGES-1:0] div_clk;
    logic [NUM_PULSES-1:0] pulses;

    stbus_frame_seq #(.CNT_W(FRAME_LOG2)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .run_q   (run_q),
        .run_nxt (run_nxt),
        .cnt_nxt (cnt_nxt)
    );

    stbus_clk_divider #(.CNT_W(FRAME_LOG2), .DIV_STAGES(DIV_STAGES)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run_nxt (run_nxt),
        .cnt_nxt (cnt_nxt),
        .clk_o   (div_clk)
    );

    generate
        for (genvar g = 0; g < NUM_PULSES; g++) begin : g_pulse
            stbus_pulse_shaper #(
                .CNT_W       (FRAME_LOG2),
                .WIDTH       (PW[g]),
                .ACTIVE_HIGH (PULSE_ACTIVE_HIGH[g])
            ) u_shaper (
                .clk     (clk),
                .rst     (rst),
                .run_nxt (run_nxt),
                .cnt_nxt (cnt_nxt),
                .pulse_o (pulses[g])
            );
        end
    endgenerate

    assign clk_16m = div_clk[0];
    assign clk_8m  = div_clk[1];
    assign clk_4m  = div_clk[2];
    assign clk_2m  = div_clk[3];
    assign fp_n_w1 = pulses[0];
    assign fp_n_w2 = pulses[1];
    assign fp_w4   = pulses[2];
    assign fp_n_w8 = pulses[3];
    assign sync_rx = pulses[4];
    assign sync_tx = pulses[5];

endmodule

// File: rtl/stbus_timing_chk.sv
module stbus_timing_chk (
    input logic clk,
    input logic rst,
    input logic run_q,
    input logic clk_16m,
    input logic clk_8m,
    input logic clk_4m,
    input logic clk_2m,
    input logic fp_n_w1,
    input logic fp_n_w2,
    input logic fp_w4,
    input logic fp_n_w8,
    input logic sync_rx,
    input logic sync_tx
);

    logic idle;
    assign idle = !clk_16m && !clk_8m && !clk_4m && !clk_2m && fp_n_w1 && fp_n_w2
                  && !fp_w4 && fp_n_w8 && !sync_rx && !sync_tx;

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> idle); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> idle); // R2

    AST_FAST_CLK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q)) |-> (clk_16m != $past(clk_16m))); // R3

    AST_FRAME_START_CLKS_LOW: assert property (@(posedge clk) disable iff (rst)
        !fp_n_w1 |-> (!clk_16m && !clk_8m && !clk_4m && !clk_2m)); // R3

    AST_NARROW_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !fp_n_w1 |=> fp_n_w1); // R5

    AST_DOUBLE_COVERS_NARROW: assert property (@(posedge clk) disable iff (rst)
        !fp_n_w1 |-> !fp_n_w2); // R6

    AST_QUAD_COVERS_DOUBLE: assert property (@(posedge clk) disable iff (rst)
        !fp_n_w2 |-> fp_w4); // R7

    AST_OCT_COVERS_QUAD: assert property (@(posedge clk) disable iff (rst)
        fp_w4 |-> !fp_n_w8); // R8

    AST_SYNC_COVERS_OCT: assert property (@(posedge clk) disable iff (rst)
        !fp_n_w8 |-> sync_rx); // R9

    AST_SYNC_PAIR: assert property (@(posedge clk) disable iff (rst)
        sync_rx == sync_tx); // R9

endmodule

bind stbus_timing_gen stbus_timing_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .run_q   (run_q),
    .clk_16m (clk_16m),
    .clk_8m  (clk_8m),
    .clk_4m  (clk_4m),
    .clk_2m  (clk_2m),
    .fp_n_w1 (fp_n_w1),
    .fp_n_w2 (fp_n_w2),
    .fp_w4   (fp_w4),
    .fp_n_w8 (fp_n_w8),
    .sync_rx (sync_rx),
    .sync_tx (sync_tx)
);

// File: tb/test_stbus_timing_gen.sv
module test_stbus_timing_gen;

    localparam int FRAME = 4096;
    localparam logic [9:0] IDLE_VEC = 10'b0000_110100;

    typedef struct packed {
        logic [15:0] k;
        logic [9:0]  vec;
    } vec_entry_t;

    // {clk_16m, clk_8m, clk_4m, clk_2m, fp_n_w1, fp_n_w2, fp_w4, fp_n_w8, sync_rx, sync_tx}
    localparam int NVEC = 12;
    localparam vec_entry_t TABLE [NVEC] = '{
        '{16'd0,    10'b0000_001011},
        '{16'd1,    10'b1000_111011},
        '{16'd2,    10'b0100_110011},
        '{16'd4,    10'b0010_110111},
        '{16'd7,    10'b1110_110111},
        '{16'd8,    10'b0001_110100},
        '{16'd4088, 10'b0001_110111},
        '{16'd4092, 10'b0011_110011},
        '{16'd4094, 10'b0111_111011},
        '{16'd4095, 10'b1111_101011},
        '{16'd4096, 10'b0000_001011},
        '{16'd4097, 10'b1000_111011}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic clk_16m, clk_8m, clk_4m, clk_2m;
    logic fp_n_w1, fp_n_w2, fp_w4, fp_n_w8, sync_rx, sync_tx;
    logic [9:0] got;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    stbus_timing_gen i_stbus_timing_gen (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .clk_16m (clk_16m),
        .clk_8m  (clk_8m),
        .clk_4m  (clk_4m),
        .clk_2m  (clk_2m),
        .fp_n_w1 (fp_n_w1),
        .fp_n_w2 (fp_n_w2),
        .fp_w4   (fp_w4),
        .fp_n_w8 (fp_n_w8),
        .sync_rx (sync_rx),
        .sync_tx (sync_tx)
    );

    assign got = {clk_16m, clk_8m, clk_4m, clk_2m, fp_n_w1, fp_n_w2, fp_w4, fp_n_w8, sync_rx, sync_tx};

    function automatic bit act(int c, int w);
        return (c < (w + 1) / 2) || (c >= FRAME - w / 2);
    endfunction

    function automatic logic [9:0] model(int c);
        return {c[0], c[1], c[2], c[3], ~act(c, 1), ~act(c, 2), act(c, 4),
                ~act(c, 8), act(c, 16), act(c, 16)};
    endfunction

    task automatic check(string tag, logic [31:0] actual, logic [31:0] expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int kcur;
        int last_start;
        int cnt_w1, cnt_w2, cnt_w4, cnt_w8, cnt_sy;
        int lo, hi;

        repeat (3) @(negedge clk);
        check("R1 reset idle", got, IDLE_VEC);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 enable low idle", got, IDLE_VEC);

        en = 1'b1;
        @(negedge clk);
        kcur = 0;
        for (int i = 0; i < NVEC; i++) begin
            while (kcur < int'(TABLE[i].k)) begin
                @(negedge clk);
                kcur++;
            end
            check($sformatf("R3/R5/R6/R7/R8/R9 table k=%0d", kcur), got, TABLE[i].vec);
        end

        last_start = -1;
        cnt_w1 = 0; cnt_w2 = 0; cnt_w4 = 0; cnt_w8 = 0; cnt_sy = 0;
        lo = 2 * FRAME - FRAME / 2;
        hi = 2 * FRAME + FRAME / 2;
        while (kcur < 3 * FRAME + 20) begin
            @(negedge clk);
            kcur++;
            if (got !== model(kcur % FRAME))
                check($sformatf("R3/R9 sweep k=%0d", kcur), got, model(kcur % FRAME));
            if (!fp_n_w1) begin
                if (last_start >= 0) check("R4 frame period", kcur - last_start, FRAME);
                last_start = kcur;
            end
            if (kcur >= lo && kcur < hi) begin
                cnt_w1 += !fp_n_w1;
                cnt_w2 += !fp_n_w2;
                cnt_w4 += fp_w4;
                cnt_w8 += !fp_n_w8;
                cnt_sy += sync_rx;
            end
        end
        check("R3 sweep completed without mismatch", errors, 0);
        check("R5 narrow width", cnt_w1, 1);
        check("R6 double width", cnt_w2, 2);
        check("R7 quad width", cnt_w4, 4);
        check("R8 octal width", cnt_w8, 8);
        check("R9 sync width", cnt_sy, 16);

        en = 1'b0;
        @(negedge clk);
        check("R2 drop enable idle", got, IDLE_VEC);
        repeat (5) @(negedge clk);
        check("R2 held idle", got, IDLE_VEC);
        en = 1'b1;
        @(negedge clk);
        check("R2 restart frame start", got, model(0));
        @(negedge clk);
        check("R2 restart second cycle", got, model(1));
        repeat (2) @(negedge clk);

        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid run", got, IDLE_VEC);
        @(negedge clk);
        check("R1 reset held", got, IDLE_VEC);
        rst = 1'b0;
        @(negedge clk);
        check("R1 release frame start", got, model(0));

        finish_run();
    end

endmodule